// File: doc/BRIEF.md
# Cluster Coherence-Unit Control Registers

This block is the register front end of a multi-core cluster's coherence unit. It occupies a 256-byte window on a plain 32-bit register bus (address, write strobe, write data, read strobe, read data). It holds a single stored bit: the coherence enable. That bit is also driven out of the block as a level for the logic it governs.

It also presents a read-only identity word, built at elaboration from the number of cores in the cluster. Every other location in the window returns zero and drops writes. This includes the power-status word, the invalidate-all word, the two address-filter bounds and the two access-permission words. Read data leaves a register, so software sees it one clock after the read strobe.

Top module: `scu_regblk`

## Requirements
- R1: A write to byte offset 0x00 stores only bit 0 of the write data, and all other bits are dropped. A read of 0x00 returns the stored bit in bit 0 with zeros above it. `snoop_en` shows the stored bit from the clock after the write.
- R2: A read of offset 0x04 returns a word with bits [3+CORES:4] set (one bit per core), `CORES-1` in bits [1:0], and zeros elsewhere. The expected words are 0x10, 0x31, 0x72 and 0xF3 for 1, 2, 3 and 4 cores. `CORES` must lie in 1..4, and any other value stops elaboration.
- R3: Writes to offset 0x04 change neither the identity word nor the stored enable.
- R4: Offset 0x08 (power status) reads as zero and writes to it have no effect.
- R5: Offset 0x0C (invalidate-all) reads as zero. A write to it is accepted and changes nothing.
- R6: Offsets 0x40 and 0x44 (filter bounds) read as zero and ignore writes.
- R7: Offsets 0x50 and 0x54 (access permission), and every offset not named in R1–R6, read as zero and ignore writes.
- R8: While `rst` is high at a clock edge, the stored enable and the read data register both clear to 0.
- R9: `bus_rdata` changes only on the clock edge that samples `bus_rd` high, and holds its value while `bus_rd` is low.
- R10: Address bits [1:0] are ignored. For example, 0x03 accesses the same word as 0x00, and 0x06 the same word as 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W (8) | Byte offset within the window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DATA_W (32) | Registered read data |
| snoop_en | output | 1 | Stored coherence enable bit |

## Verification
Both results of this block arrive exactly one clock edge after their strobe. Read data is captured on the edge that samples `bus_rd`, and the enable bit updates on the edge that samples `bus_wr`. The bench drives every strobe on a falling edge and drops it on the next falling edge, and it samples the outputs there, half a period after the edge that produced them. The latency check samples `bus_rdata` while the strobe is still high and before the capturing edge, where it must still hold the previous value. A second check a few idle cycles later confirms that the value has not moved.

// File: rtl/scu_regs_pkg.sv
package scu_regs_pkg;

  // Word indices (byte offset >> 2) of the decoded locations.
  localparam logic [5:0] IDX_CTRL   = 6'h00;
  localparam logic [5:0] IDX_CFG    = 6'h01;
  localparam logic [5:0] IDX_PWR    = 6'h02;
  localparam logic [5:0] IDX_INV    = 6'h03;
  localparam logic [5:0] IDX_FLT_LO = 6'h10;
  localparam logic [5:0] IDX_FLT_HI = 6'h11;
  localparam logic [5:0] IDX_ACC_S  = 6'h14;
  localparam logic [5:0] IDX_ACC_NS = 6'h15;

  // Identity word layout.
  localparam int MAX_CORES = 4;
  localparam int MASK_LSB  = 4;
  localparam int CNT_W     = 2;

  typedef enum logic [2:0] {
    SEL_CTRL,
    SEL_CFG,
    SEL_PWR,
    SEL_INV,
    SEL_FLT,
    SEL_ACC,
    SEL_NONE
  } scu_sel_e;

endpackage

// File: rtl/scu_addr_dec.sv
module scu_addr_dec
  import scu_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output scu_sel_e          sel
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic             unused_lsbs;

  assign widx        = addr[ADDR_W-1:2];
  assign unused_lsbs = ^addr[1:0];

  always_comb begin
    if (widx == IDX_W'(IDX_CTRL))
      sel = SEL_CTRL;
    else if (widx == IDX_W'(IDX_CFG))
      sel = SEL_CFG;
    else if (widx == IDX_W'(IDX_PWR))
      sel = SEL_PWR;
    else if (widx == IDX_W'(IDX_INV))
      sel = SEL_INV;
    else if (widx == IDX_W'(IDX_FLT_LO) || widx == IDX_W'(IDX_FLT_HI))
      sel = SEL_FLT;
    else if (widx == IDX_W'(IDX_ACC_S) || widx == IDX_W'(IDX_ACC_NS))
      sel = SEL_ACC;
    else
      sel = SEL_NONE;
  end
endmodule

// File: rtl/scu_cfg_word.sv
module scu_cfg_word
  import scu_regs_pkg::*;
#(
  parameter int CORES  = 4,
  parameter int DATA_W = 32
) (
  output logic [DATA_W-1:0] cfg_word
);
  // R2: legal core counts are 1..MAX_CORES
  generate
    if (CORES < 1 || CORES > MAX_CORES) begin : g_bad_cores
      $error("scu_cfg_word: CORES must be within 1..4");
    end
  endgenerate

  always_comb begin
    cfg_word = '0;
    for (int i = 0; i < MAX_CORES; i++) begin
      if (i < CORES) cfg_word[MASK_LSB+i] = 1'b1;
    end
    cfg_word[CNT_W-1:0] = CNT_W'(CORES - 1);
  end
endmodule

// File: rtl/scu_ctrl_bit.sv
module scu_ctrl_bit (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= 1'b0;
    else if (we)
      q <= d;
  end
endmodule

// File: rtl/scu_regblk.sv
module scu_regblk
  import scu_regs_pkg::*;
#(
  parameter int CORES  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              snoop_en
);
  scu_sel_e          sel;
  logic [DATA_W-1:0] cfg_word;
  logic              ctrl_we;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:1];

  scu_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  scu_cfg_word #(.CORES(CORES), .DATA_W(DATA_W)) u_cfg (
    .cfg_word (cfg_word)
  );

  // Only the control word holds state; every other write is dropped.
  assign ctrl_we = bus_wr && (sel == SEL_CTRL);

  scu_ctrl_bit u_ctrl (
    .clk (clk),
    .rst (rst),
    .we  (ctrl_we),
    .d   (bus_wdata[0]),
    .q   (snoop_en)
  );

  // Registered read path, updated only on a read strobe.
  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd) begin
      case (sel)
        SEL_CTRL: bus_rdata <= {{(DATA_W-1){1'b0}}, snoop_en};
        SEL_CFG:  bus_rdata <= cfg_word;
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/scu_regblk_chk.sv
module scu_regblk_chk #(
  parameter int CORES  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              snoop_en
);
  function automatic logic [DATA_W-1:0] ident(input int n);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int k = 0; k < n; k++) w[4+k] = 1'b1;
    w[1:0] = 2'(n - 1);
    return w;
  endfunction

  logic [ADDR_W-3:0] widx;
  assign widx = bus_addr[ADDR_W-1:2];

  assert_reset_clear_R8: assert property (@(posedge clk)
    $fell(rst) |-> (!snoop_en && bus_rdata == '0));

  assert_ctrl_write_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && widx == '0) |=> (snoop_en == $past(bus_wdata[0])));

  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && widx == '0) |=> $stable(snoop_en));

  assert_ctrl_read_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && widx == '0) |=> (bus_rdata == {{(DATA_W-1){1'b0}}, $past(snoop_en)}));

  assert_ident_read_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && widx == 1) |=> (bus_rdata == ident(CORES)));

  assert_zero_read_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && widx > 1) |=> (bus_rdata == '0));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind scu_regblk scu_regblk_chk #(.CORES(CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .snoop_en  (snoop_en)
);

// File: tb/scu_regblk_tb_top.sv
module scu_regblk_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd = 1'b0;
  logic [31:0] rdata;
  logic        en;
  logic [31:0] aux_rdata [1:3];
  logic        aux_en [1:3];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scu_regblk #(.CORES(4)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rd(rd), .bus_rdata(rdata), .snoop_en(en)
  );

  for (genvar g = 1; g <= 3; g++) begin : g_aux
    scu_regblk #(.CORES(g)) aux_i (
      .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
      .bus_rd(rd), .bus_rdata(aux_rdata[g]), .snoop_en(aux_en[g])
    );
  end

  // Vector: {req[3:0], is_write, addr[7:0], wdata[31:0], exp_rdata[31:0], exp_en}
  localparam int NV = 20;
  localparam logic [77:0] VEC [NV] = '{
    {4'd1,  1'b0, 8'h00, 32'h0,        32'h0,  1'b0}, // R1 read after reset
    {4'd1,  1'b1, 8'h00, 32'hFFFFFFFE, 32'h0,  1'b0}, // R1 upper bits dropped
    {4'd1,  1'b1, 8'h00, 32'h00000001, 32'h0,  1'b1}, // R1 set enable
    {4'd1,  1'b0, 8'h00, 32'h0,        32'h1,  1'b1}, // R1 read back
    {4'd2,  1'b0, 8'h04, 32'h0,        32'hF3, 1'b1}, // R2 four cores
    {4'd3,  1'b1, 8'h04, 32'hFFFFFFFF, 32'h0,  1'b1}, // R3 write ignored
    {4'd3,  1'b0, 8'h04, 32'h0,        32'hF3, 1'b1}, // R3 word unchanged
    {4'd4,  1'b1, 8'h08, 32'h00000000, 32'h0,  1'b1}, // R4
    {4'd4,  1'b0, 8'h08, 32'h0,        32'h0,  1'b1}, // R4
    {4'd5,  1'b1, 8'h0C, 32'h00000000, 32'h0,  1'b1}, // R5
    {4'd5,  1'b0, 8'h0C, 32'h0,        32'h0,  1'b1}, // R5
    {4'd6,  1'b1, 8'h40, 32'h00000000, 32'h0,  1'b1}, // R6
    {4'd6,  1'b0, 8'h44, 32'h0,        32'h0,  1'b1}, // R6
    {4'd7,  1'b1, 8'h54, 32'h00000000, 32'h0,  1'b1}, // R7
    {4'd7,  1'b0, 8'h50, 32'h0,        32'h0,  1'b1}, // R7
    {4'd7,  1'b0, 8'hFC, 32'h0,        32'h0,  1'b1}, // R7 unnamed offset
    {4'd10, 1'b0, 8'h03, 32'h0,        32'h1,  1'b1}, // R10 alias of 0x00
    {4'd10, 1'b0, 8'h06, 32'h0,        32'hF3, 1'b1}, // R10 alias of 0x04
    {4'd10, 1'b1, 8'h02, 32'h00000000, 32'h0,  1'b0}, // R10 write via alias
    {4'd1,  1'b0, 8'h00, 32'h0,        32'h0,  1'b0}  // R1 cleared
  };

  function automatic logic [31:0] ident(input int n);
    return (((32'd1 << n) - 32'd1) << 4) | 32'(n - 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R8 rdata after reset", rdata, 32'h0);
    check("R8 enable after reset", {31'b0, en}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [77:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vector %0d", v[77:74], i);
      if (v[73]) begin
        bus_write(v[72:65], v[64:33]);
      end else begin
        bus_read(v[72:65]);
        check(tag, rdata, v[32:1]);
      end
      check(tag, {31'b0, en}, {31'b0, v[0]});
    end

    // R2: identity word for every smaller core count
    bus_read(8'h04);
    for (int n = 1; n <= 3; n++)
      check($sformatf("R2 cores=%0d", n), aux_rdata[n], ident(n));
    check("R2 cores=4", rdata, ident(4));

    // R9: one-cycle latency, hold while idle
    bus_read(8'h08);
    @(negedge clk);
    addr = 8'h04; rd = 1'b1;
    #1 check("R9 no change before edge", rdata, 32'h0);
    @(negedge clk);
    rd = 1'b0; addr = 8'h00;
    check("R9 updated one cycle later", rdata, 32'hF3);
    repeat (3) @(negedge clk);
    check("R9 holds while idle", rdata, 32'hF3);

    // R8: reset in mid-run clears stored bit and read data
    bus_write(8'h00, 32'h1);
    check("R8 enable set before reset", {31'b0, en}, 32'h1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R8 enable cleared", {31'b0, en}, 32'h0);
    check("R8 rdata cleared", rdata, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule